// File: doc/BRIEF.md
# Counter Trigger Front End

This block conditions one hardware trigger for one event of a counter channel, such as start, reload, stop, count or capture. It picks one of sixteen sources: fourteen external trigger lines, a tied-low source and a tied-high source. The chosen level passes through a two-flop synchronizer and then through an optional glitch filter. The filter accepts a new level only after that level has held for a programmable number of clock cycles.

An edge stage turns the filtered level into an event. In rising, falling or any-edge mode it emits a one-clock pulse. In pass-through mode it forwards the level as it is.

A software fire request is merged into the event. The request is a strobe together with a bit mask that has one bit per channel, so a single write can fire several channels in the same clock. A channel responds when the mask bit at its own index is set.

Top module: `trig_event_front`

## Requirements
- R1: While `rst_n` is low, `evt_out` is 0. After reset it stays 0 until an input causes an event.
- R2: With `src_sel` equal to a value n from 0 to 13, the level of `trig_in[n]` is used and every other trigger line has no effect. With the filter off, a change on the selected line that is set up before clock edge k reaches the edge stage so that the event is visible after clock edge k+3.
- R3: `src_sel` = 14 selects a constant 0 and `src_sel` = 15 selects a constant 1; with either selected, no activity on `trig_in` produces an event. Moving the selection from a low line to 15 counts as a rising change of the source level.
- R4: Edge mode 0 (rising) emits one pulse for each 0-to-1 change of the filtered level, and none for 1-to-0 changes.
- R5: Edge mode 1 (falling) emits one pulse for each 1-to-0 change of the filtered level, and none for 0-to-1 changes.
- R6: Edge mode 2 (any) emits one pulse for each change of the filtered level, in either direction.
- R7: Edge mode 3 (pass-through) drives `evt_out` with the filtered level, delayed by the same latency as an edge event.
- R8: With `filt_en` = 1 and `filt_depth` = N ≥ 2, a level held for fewer than N cycles never reaches the edge stage.
- R9: With `filt_en` = 1 and `filt_depth` = N, a level held for at least N cycles is accepted. Its event appears N−1 cycles later than it would with the filter off. A depth of 0 behaves like a depth of 1.
- R10: A `sw_strobe` high while `sw_mask[CH_IDX]` is 1 makes `evt_out` high after the next clock edge, in every edge mode. Mask bits of other channels have no effect.
- R11: In the edge modes, an edge event lasts exactly one clock cycle, even when the new level is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_EXT (14) | External trigger lines |
| src_sel | input | SEL_W (4) | Source choice: 0..13 lines, 14 constant 0, 15 constant 1 |
| edge_mode | input | 2 | 0 rising, 1 falling, 2 any, 3 pass-through |
| filt_en | input | 1 | Enables the glitch filter |
| filt_depth | input | FD_W (4) | Cycles a new level must hold before it is accepted |
| sw_strobe | input | 1 | Software fire strobe |
| sw_mask | input | NUM_CH (8) | Per-channel fire mask, bit CH_IDX belongs to this instance |
| evt_out | output | 1 | Event pulse, or level in pass-through mode |

## Verification
The hardest case to reach from the ports is a pulse that sits just short of the filter depth. Its counter has to climb to one below the threshold and then be cleared by a level that returns to its old value, and the accepted case has to land on the exact cycle the depth predicts. The stimulus drives the selected line high for three cycles under a depth of four and requires silence. It then holds the line for longer and requires the pulse on the single cycle the depth predicts. The constant sources are also reached by switching the selector rather than the lines, which produces a rising change that no trigger line caused.

// File: rtl/trig_fe_pkg.sv
package trig_fe_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_PASS = 2'd3
  } edge_mode_e;

  // Event decision from the present and previous filtered level.
  function automatic logic edge_fire(edge_mode_e mode, logic cur, logic prv);
    logic hit;
    case (mode)
      EDGE_RISE: hit = cur & ~prv;
      EDGE_FALL: hit = ~cur & prv;
      EDGE_ANY:  hit = cur ^ prv;
      default:   hit = cur;
    endcase
    return hit;
  endfunction

  // True once the differing level has been seen for depth cycles.
  // A depth of zero behaves like a depth of one.
  function automatic logic filt_done(int unsigned seen, int unsigned depth);
    return (seen + 1) >= depth;
  endfunction

endpackage

// File: rtl/trig_src_sync.sv
module trig_src_sync #(
  parameter int NUM_EXT = 14,
  parameter int SEL_W   = $clog2(NUM_EXT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] lines,
  input  logic [SEL_W-1:0]   sel,
  output logic               sync_lvl
);

  localparam int NUM_SRC = NUM_EXT + 2;

  logic [NUM_SRC-1:0] src_vec;
  logic               picked;
  logic               meta_q;
  logic               sync_q;

  // Source vector: external lines, then constant 0, then constant 1.
  generate
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_line
      assign src_vec[i] = lines[i];
    end
  endgenerate
  assign src_vec[NUM_EXT]     = 1'b0;
  assign src_vec[NUM_EXT + 1] = 1'b1;

  // Out-of-range selections read as low.
  always_comb begin
    picked = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (int'(sel) == s) picked = src_vec[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= picked;
      sync_q <= meta_q;
    end
  end

  assign sync_lvl = sync_q;

endmodule

// File: rtl/trig_glitch_filt.sv
module trig_glitch_filt
  import trig_fe_pkg::*;
#(
  parameter int FD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic            en,
  input  logic [FD_W-1:0] depth,
  output logic            dout
);

  logic            lvl_q;
  logic [FD_W-1:0] seen_q;
  logic            differ;
  logic            accept;

  assign differ = (din != lvl_q);
  assign accept = filt_done(32'(seen_q), 32'(depth));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      seen_q <= '0;
    end else if (!en) begin
      lvl_q  <= din;
      seen_q <= '0;
    end else if (!differ) begin
      seen_q <= '0;
    end else if (accept) begin
      lvl_q  <= din;
      seen_q <= '0;
    end else begin
      seen_q <= seen_q + 1'b1;
    end
  end

  assign dout = lvl_q;

  // A new output level is always one the input actually held.
  assert_filt_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> lvl_q == $past(din));

  // No change while the run counter is still empty and the depth is above one.
  assert_glitch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && depth > 1 && seen_q == '0) |=> $stable(lvl_q));

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
  import trig_fe_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  edge_mode_e        mode,
  input  logic              sw_strobe,
  input  logic [NUM_CH-1:0] sw_mask,
  output logic              evt
);

  logic prev_q;
  logic evt_q;
  logic sw_hit;
  logic det_hit;

  assign sw_hit  = sw_strobe & sw_mask[CH_IDX];
  assign det_hit = edge_fire(mode, lvl, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      evt_q  <= det_hit | sw_hit;
    end
  end

  assign evt = evt_q;

  assert_sw_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> evt);

  assert_rise_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_RISE && !sw_hit && !lvl) |=> !evt);

  assert_fall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_FALL && !sw_hit && lvl) |=> !evt);

  assert_pass_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_PASS && lvl) |=> evt);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_RISE && lvl && prev_q && !sw_hit) |=> !evt);

endmodule

// File: rtl/trig_event_front.sv
module trig_event_front
  import trig_fe_pkg::*;
#(
  parameter int NUM_EXT = 14,
  parameter int SEL_W   = $clog2(NUM_EXT + 2),
  parameter int FD_W    = 4,
  parameter int NUM_CH  = 8,
  parameter int CH_IDX  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] trig_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [1:0]         edge_mode,
  input  logic               filt_en,
  input  logic [FD_W-1:0]    filt_depth,
  input  logic               sw_strobe,
  input  logic [NUM_CH-1:0]  sw_mask,
  output logic               evt_out
);

  localparam logic [SEL_W-1:0] SEL_LOW = SEL_W'(NUM_EXT);

  logic       sync_lvl;
  logic       filt_lvl;
  edge_mode_e mode_e;

  assign mode_e = edge_mode_e'(edge_mode);

  trig_src_sync #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (trig_in),
    .sel      (src_sel),
    .sync_lvl (sync_lvl)
  );

  trig_glitch_filt #(.FD_W(FD_W)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sync_lvl),
    .en    (filt_en),
    .depth (filt_depth),
    .dout  (filt_lvl)
  );

  trig_edge_det #(.NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (filt_lvl),
    .mode      (mode_e),
    .sw_strobe (sw_strobe),
    .sw_mask   (sw_mask),
    .evt       (evt_out)
  );

  // Two cycles on the constant-low source leave the synchronized level low.
  assert_const_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == SEL_LOW && $past(src_sel, 2) == SEL_LOW) |-> !sync_lvl);

endmodule

// File: tb/trig_event_front_bench.sv
module trig_event_front_bench;

  localparam int NUM_EXT = 14;
  localparam int SEL_W   = 4;
  localparam int FD_W    = 4;
  localparam int NUM_CH  = 8;
  localparam int CH_IDX  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EXT-1:0] trig_in = '0;
  logic [SEL_W-1:0]   src_sel = '0;
  logic [1:0]         edge_mode = 2'd0;
  logic               filt_en = 1'b0;
  logic [FD_W-1:0]    filt_depth = '0;
  logic               sw_strobe = 1'b0;
  logic [NUM_CH-1:0]  sw_mask = '0;
  logic               evt_out;

  always #4 clk = ~clk;

  trig_event_front #(
    .NUM_EXT(NUM_EXT), .SEL_W(SEL_W), .FD_W(FD_W), .NUM_CH(NUM_CH), .CH_IDX(CH_IDX)
  ) u_trig_event_front (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src_sel(src_sel),
    .edge_mode(edge_mode), .filt_en(filt_en), .filt_depth(filt_depth),
    .sw_strobe(sw_strobe), .sw_mask(sw_mask), .evt_out(evt_out)
  );

  typedef struct {
    int    cyc;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    unexp = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // Driver helpers: all stimulus changes at the falling edge.
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int c, input string r);
    exp_t e;
    e.cyc = c;
    e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic quiet(input int n, input string r);
    int u0;
    cur_req = r;
    u0 = unexp;
    tick(n);
    if (unexp == u0) checks++;
  endtask

  // Monitor: compares evt_out with the expected pulse list every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        checks++;
        if (evt_out !== 1'b1) begin
          fails++;
          $display("FAIL %s cycle %0d: evt_out=%b expected 1", exp_q[0].req, cyc, evt_out);
        end
        void'(exp_q.pop_front());
      end else if (evt_out !== 1'b0) begin
        checks++;
        fails++;
        unexp++;
        $display("FAIL %s cycle %0d: evt_out=%b expected 0", cur_req, cyc, evt_out);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p;
    // R1: reset state
    tick(3);
    checks++;
    if (evt_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: evt_out=%b expected 0 in reset", evt_out);
    end
    rst_n = 1'b1;
    quiet(6, "R1");

    // R4 / R2: rising edge on line 5, filter off, latency 4 from drive
    src_sel = 4'd5;
    edge_mode = 2'd0;
    p = cyc;
    trig_in[5] = 1'b1;
    expect_at(p + 4, "R4");
    quiet(10, "R11");
    trig_in[5] = 1'b0;
    quiet(8, "R4");

    // R2: unselected lines ignored
    trig_in[3] = 1'b1;
    trig_in[6] = 1'b1;
    quiet(8, "R2");
    trig_in[3] = 1'b0;
    trig_in[6] = 1'b0;
    quiet(8, "R2");

    // R5: falling mode
    edge_mode = 2'd1;
    trig_in[5] = 1'b1;
    quiet(8, "R5");
    p = cyc;
    trig_in[5] = 1'b0;
    expect_at(p + 4, "R5");
    quiet(8, "R5");

    // R6: any edge
    edge_mode = 2'd2;
    p = cyc;
    trig_in[5] = 1'b1;
    expect_at(p + 4, "R6");
    quiet(8, "R6");
    p = cyc;
    trig_in[5] = 1'b0;
    expect_at(p + 4, "R6");
    quiet(8, "R6");

    // R7: pass-through follows the level for four cycles
    edge_mode = 2'd3;
    p = cyc;
    trig_in[5] = 1'b1;
    for (int i = 0; i < 4; i++) expect_at(p + 4 + i, "R7");
    tick(4);
    trig_in[5] = 1'b0;
    quiet(8, "R7");

    // R3: constant sources
    edge_mode = 2'd0;
    p = cyc;
    src_sel = 4'd15;
    expect_at(p + 4, "R3");
    quiet(8, "R3");
    trig_in = '1;
    quiet(4, "R3");
    trig_in = '0;
    quiet(6, "R3");
    src_sel = 4'd14;
    quiet(6, "R3");
    trig_in = '1;
    quiet(4, "R3");
    trig_in = '0;
    quiet(6, "R3");
    src_sel = 4'd5;
    quiet(4, "R3");

    // R8: glitch shorter than depth is dropped
    filt_en = 1'b1;
    filt_depth = 4'd4;
    trig_in[5] = 1'b1;
    tick(3);
    trig_in[5] = 1'b0;
    quiet(12, "R8");

    // R9: level held past depth accepted, N-1 extra cycles
    p = cyc;
    trig_in[5] = 1'b1;
    expect_at(p + 7, "R9");
    quiet(14, "R9");
    trig_in[5] = 1'b0;
    quiet(12, "R9");
    filt_en = 1'b0;
    filt_depth = '0;
    quiet(4, "R9");

    // R10: software fire with own mask bit, then with another channel's bit
    p = cyc;
    sw_strobe = 1'b1;
    sw_mask = 8'b0000_0100;
    expect_at(p + 1, "R10");
    tick(1);
    sw_strobe = 1'b0;
    quiet(4, "R10");
    sw_strobe = 1'b1;
    sw_mask = 8'b0010_0000;
    tick(1);
    sw_strobe = 1'b0;
    sw_mask = 8'b0000_0100;
    quiet(6, "R10");

    tick(4);
    while (exp_q.size() > 0) begin
      checks++;
      fails++;
      $display("FAIL %s: pulse missing at cycle %0d, actual 0 expected 1", exp_q[0].req, exp_q[0].cyc);
      void'(exp_q.pop_front());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule